// File: doc/BRIEF.md
# Trap and Reset Vectoring Sequencer

This block decides, for a 32-bit RISC core, what happens to the architectural state when the core is reset, raises a hardware exception, receives a break, or executes a user-vector trap. Each cycle it looks at the pending requests. The highest-priority request that is currently allowed wins. The sequencer then spends one cycle driving a program-counter redirect and the write ports of the general-purpose register file, the machine status register (MSR), the exception status register (ESR), the exception address register (EAR), the branch-target register (BTR) and the floating-point status register (FSR). The MSR itself lives outside the block: its current value comes in on `msr_cur`, and any change leaves on the `msr_we`/`msr_data` port.

The behaviour is a five-state machine. `ST_RESET` is entered from any state whenever `rst` is sampled high. It leaves to `ST_RUN` on the first edge at which `rst` is low. In `ST_RUN` the arbiter picks an event:
- an allowed exception moves to `ST_EXC`;
- an allowed break moves to `ST_BRK`;
- a user trap moves to `ST_TRAP`;
- no event stays in `ST_RUN`.

`ST_EXC`, `ST_BRK` and `ST_TRAP` each last one cycle and always return to `ST_RUN`. While in `ST_RUN`, the request payload (PC, delay-slot flag, branch target, cause fields, MSR) is captured on every edge. The write ports in the vectoring cycle therefore reflect the cycle in which the event was accepted.

An exception raised by an instruction in a branch delay slot cannot return to PC+4. In that case the sequencer saves the branch target in BTR, marks ESR as a delay-slot exception and leaves the return-address register untouched.

Top module: `trap_vector_ctl`

## Requirements
- R1: While `ST_RESET` is active (from the edge after `rst` is sampled high until the first edge at which it is low), the block drives `redirect_pc` = 0x00000000, writes `RESET_MSR` to the MSR, and writes zero to ESR, EAR and FSR. It does not write a general register or BTR. Reset overrides any other request.
- R2: An exception request made in `ST_RUN` while MSR bit 8 (exception enable) is 1 produces, one cycle later, a redirect to 0x00000020. The MSR is written with its captured value, bit 8 cleared and bit 9 (exception in progress) set.
- R3: On an accepted exception, ESR is written as {delay-slot flag at bit 12, detail at bits 11:5, cause at bits 4:0}. EAR receives the faulting address and FSR receives the supplied floating-point status.
- R4: When the accepted exception was in a delay slot, ESR bit 12 is 1 and BTR is written with the pending branch target. No general register is written.
- R5: When the accepted exception was not in a delay slot, ESR bit 12 is 0 and register 17 is written with PC+4 (modulo 2^32). BTR is not written.
- R6: A break from either the hardware or the software source, accepted while MSR bit 3 (break in progress) is 0, writes PC into register 16, redirects to 0x00000018, and writes the MSR with bit 3 set. ESR is not written.
- R7: A break request is ignored while MSR bit 3 is 1. An exception request is ignored while MSR bit 8 is 0.
- R8: A user trap writes PC into the register named by `trap_link`, redirects to 0x00000008, and does not write the MSR.
- R9: Priority is reset, then exception, then break, then user trap. A request that is currently not allowed does not block a lower-priority one.
- R10: At most one event is taken per vectoring cycle. Requests present during a vectoring cycle are ignored. In `ST_RUN` all write ports and the redirect are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous architectural reset, active high |
| exc_req | input | 1 | Hardware exception request |
| exc_cause | input | 5 | Exception cause code |
| exc_detail | input | 7 | Cause-specific detail for ESR |
| exc_addr | input | 32 | Faulting address for EAR |
| exc_fsr | input | 5 | Floating-point status to record |
| brk_hw | input | 1 | External hardware break request |
| brk_sw | input | 1 | Internal software break request |
| trap_req | input | 1 | User-vector trap request |
| trap_link | input | 5 | Link register index for the user trap |
| pc_cur | input | 32 | PC of the current instruction |
| in_delay_slot | input | 1 | Current instruction sits in a delay slot |
| branch_target | input | 32 | Target of the pending branch |
| msr_cur | input | 32 | Current MSR value |
| redirect_valid | output | 1 | PC redirect strobe |
| redirect_pc | output | 32 | New PC |
| gpr_we | output | 1 | General register write enable |
| gpr_addr | output | 5 | General register index |
| gpr_data | output | 32 | General register write data |
| msr_we | output | 1 | MSR write enable |
| msr_data | output | 32 | MSR write data |
| esr_we | output | 1 | ESR write enable |
| esr_data | output | 13 | ESR write data |
| ear_we | output | 1 | EAR write enable |
| ear_data | output | 32 | EAR write data |
| btr_we | output | 1 | BTR write enable |
| btr_data | output | 32 | BTR write data |
| fsr_we | output | 1 | FSR write enable |
| fsr_data | output | 5 | FSR write data |

## Verification
The hardest cases to reach are those where several requests arrive together and the higher-priority one is masked by the MSR. Examples are an exception while exception enable is clear, arriving alongside a break while break-in-progress is set and a user trap. Only such a mix shows that a masked request neither wins nor blocks. The stimulus sweeps every combination of the seven control inputs (exception request, enable bit, both break sources, break-in-progress bit, trap request, delay-slot flag) in one pass from `ST_RUN`. It holds each pattern through the vectoring cycle to show that requests there are dropped. It also places a PC of 0xFFFFFFFC on an ordinary exception to check the wrap of the return address.

// File: rtl/trapv_pkg.sv
package trapv_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_RUN   = 3'd1,
        ST_EXC   = 3'd2,
        ST_BRK   = 3'd3,
        ST_TRAP  = 3'd4
    } trapv_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_BRK  = 2'd2,
        EV_TRAP = 2'd3
    } trapv_evt_e;

endpackage

// File: rtl/trapv_arbiter.sv
module trapv_arbiter
    import trapv_pkg::*;
#(
    parameter int BRK_SRCS = 2
) (
    input  logic                exc_req,
    input  logic                msr_ee,
    input  logic [BRK_SRCS-1:0] brk_srcs,
    input  logic                msr_bip,
    input  logic                trap_req,
    output trapv_evt_e          evt
);

    logic exc_ok;
    logic brk_any;
    logic brk_ok;

    // Any break source counts; break-in-progress masks them all.
    assign brk_any = |brk_srcs;
    assign exc_ok  = exc_req && msr_ee;
    assign brk_ok  = brk_any && !msr_bip;

    // Fixed priority among allowed requests (R9); reset is handled in the FSM.
    always_comb begin
        if (exc_ok) begin
            evt = EV_EXC;
        end else if (brk_ok) begin
            evt = EV_BRK;
        end else if (trap_req) begin
            evt = EV_TRAP;
        end else begin
            evt = EV_NONE;
        end
    end

endmodule

// File: rtl/trapv_fsm.sv
module trapv_fsm
    import trapv_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  trapv_evt_e   evt,
    output trapv_state_e state
);

    trapv_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET: state_nxt = ST_RUN;
            ST_RUN: begin
                unique case (evt)
                    EV_EXC:  state_nxt = ST_EXC;
                    EV_BRK:  state_nxt = ST_BRK;
                    EV_TRAP: state_nxt = ST_TRAP;
                    EV_NONE: state_nxt = ST_RUN;
                    default: state_nxt = ST_RUN;
                endcase
            end
            ST_EXC:  state_nxt = ST_RUN;
            ST_BRK:  state_nxt = ST_RUN;
            ST_TRAP: state_nxt = ST_RUN;
            default: state_nxt = ST_RESET;
        endcase
        // Reset takes precedence over every transition (R1, R9).
        if (rst) begin
            state_nxt = ST_RESET;
        end
    end

    always_ff @(posedge clk) begin
        state <= state_nxt;
    end

endmodule

// File: rtl/trapv_capture.sv
module trapv_capture #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5,
    parameter int EC_W   = 5,
    parameter int ESS_W  = 7,
    parameter int FSR_W  = 5
) (
    input  logic              clk,
    input  logic              load,
    input  logic [XLEN-1:0]   pc_in,
    input  logic              ds_in,
    input  logic [XLEN-1:0]   btgt_in,
    input  logic [EC_W-1:0]   ec_in,
    input  logic [ESS_W-1:0]  ess_in,
    input  logic [XLEN-1:0]   ear_in,
    input  logic [FSR_W-1:0]  fsr_in,
    input  logic [REG_AW-1:0] link_in,
    input  logic [XLEN-1:0]   msr_in,
    output logic [XLEN-1:0]   pc_q,
    output logic              ds_q,
    output logic [XLEN-1:0]   btgt_q,
    output logic [EC_W-1:0]   ec_q,
    output logic [ESS_W-1:0]  ess_q,
    output logic [XLEN-1:0]   ear_q,
    output logic [FSR_W-1:0]  fsr_q,
    output logic [REG_AW-1:0] link_q,
    output logic [XLEN-1:0]   msr_q
);

    // Payload follows the inputs while running and freezes while vectoring.
    always_ff @(posedge clk) begin
        if (load) begin
            pc_q   <= pc_in;
            ds_q   <= ds_in;
            btgt_q <= btgt_in;
            ec_q   <= ec_in;
            ess_q  <= ess_in;
            ear_q  <= ear_in;
            fsr_q  <= fsr_in;
            link_q <= link_in;
            msr_q  <= msr_in;
        end
    end

endmodule

// File: rtl/trapv_writer.sv
module trapv_writer
    import trapv_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              REG_AW     = 5,
    parameter int              EC_W       = 5,
    parameter int              ESS_W      = 7,
    parameter int              FSR_W      = 5,
    parameter int              EE_BIT     = 8,
    parameter int              EIP_BIT    = 9,
    parameter int              BIP_BIT    = 3,
    parameter int              EXC_LINK   = 17,
    parameter int              BRK_LINK   = 16,
    parameter logic [XLEN-1:0] RESET_MSR  = '0,
    parameter logic [XLEN-1:0] VEC_RESET  = 'h00,
    parameter logic [XLEN-1:0] VEC_TRAP   = 'h08,
    parameter logic [XLEN-1:0] VEC_BRK    = 'h18,
    parameter logic [XLEN-1:0] VEC_EXC    = 'h20,
    parameter logic [XLEN-1:0] INSN_BYTES = 'h4,
    localparam int             ESR_W      = EC_W + ESS_W + 1
) (
    input  trapv_state_e      state,
    input  logic [XLEN-1:0]   pc_q,
    input  logic              ds_q,
    input  logic [XLEN-1:0]   btgt_q,
    input  logic [EC_W-1:0]   ec_q,
    input  logic [ESS_W-1:0]  ess_q,
    input  logic [XLEN-1:0]   ear_q,
    input  logic [FSR_W-1:0]  fsr_q,
    input  logic [REG_AW-1:0] link_q,
    input  logic [XLEN-1:0]   msr_q,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              gpr_we,
    output logic [REG_AW-1:0] gpr_addr,
    output logic [XLEN-1:0]   gpr_data,
    output logic              msr_we,
    output logic [XLEN-1:0]   msr_data,
    output logic              esr_we,
    output logic [ESR_W-1:0]  esr_data,
    output logic              ear_we,
    output logic [XLEN-1:0]   ear_data,
    output logic              btr_we,
    output logic [XLEN-1:0]   btr_data,
    output logic              fsr_we,
    output logic [FSR_W-1:0]  fsr_data
);

    logic [XLEN-1:0] msr_exc;
    logic [XLEN-1:0] msr_brk;

    always_comb begin
        msr_exc          = msr_q;
        msr_exc[EE_BIT]  = 1'b0;
        msr_exc[EIP_BIT] = 1'b1;
        msr_brk          = msr_q;
        msr_brk[BIP_BIT] = 1'b1;
    end

    always_comb begin
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        gpr_we         = 1'b0;
        gpr_addr       = '0;
        gpr_data       = '0;
        msr_we         = 1'b0;
        msr_data       = '0;
        esr_we         = 1'b0;
        esr_data       = '0;
        ear_we         = 1'b0;
        ear_data       = '0;
        btr_we         = 1'b0;
        btr_data       = '0;
        fsr_we         = 1'b0;
        fsr_data       = '0;
        unique case (state)
            ST_RESET: begin
                redirect_valid = 1'b1;
                redirect_pc    = VEC_RESET;
                msr_we         = 1'b1;
                msr_data       = RESET_MSR;
                esr_we         = 1'b1;
                ear_we         = 1'b1;
                fsr_we         = 1'b1;
            end
            ST_RUN: begin
                redirect_valid = 1'b0;
            end
            ST_EXC: begin
                redirect_valid = 1'b1;
                redirect_pc    = VEC_EXC;
                msr_we         = 1'b1;
                msr_data       = msr_exc;
                esr_we         = 1'b1;
                esr_data       = {ds_q, ess_q, ec_q};
                ear_we         = 1'b1;
                ear_data       = ear_q;
                fsr_we         = 1'b1;
                fsr_data       = fsr_q;
                if (ds_q) begin
                    // Return address is meaningless; keep the branch target instead.
                    btr_we   = 1'b1;
                    btr_data = btgt_q;
                end else begin
                    gpr_we   = 1'b1;
                    gpr_addr = REG_AW'(EXC_LINK);
                    gpr_data = pc_q + INSN_BYTES;
                end
            end
            ST_BRK: begin
                redirect_valid = 1'b1;
                redirect_pc    = VEC_BRK;
                gpr_we         = 1'b1;
                gpr_addr       = REG_AW'(BRK_LINK);
                gpr_data       = pc_q;
                msr_we         = 1'b1;
                msr_data       = msr_brk;
            end
            ST_TRAP: begin
                redirect_valid = 1'b1;
                redirect_pc    = VEC_TRAP;
                gpr_we         = 1'b1;
                gpr_addr       = link_q;
                gpr_data       = pc_q;
            end
            default: begin
                redirect_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trap_vector_ctl.sv
module trap_vector_ctl
    import trapv_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              REG_AW     = 5,
    parameter int              EC_W       = 5,
    parameter int              ESS_W      = 7,
    parameter int              FSR_W      = 5,
    parameter int              EE_BIT     = 8,
    parameter int              EIP_BIT    = 9,
    parameter int              BIP_BIT    = 3,
    parameter int              EXC_LINK   = 17,
    parameter int              BRK_LINK   = 16,
    parameter logic [XLEN-1:0] RESET_MSR  = 'h100,
    parameter logic [XLEN-1:0] VEC_RESET  = 'h00,
    parameter logic [XLEN-1:0] VEC_TRAP   = 'h08,
    parameter logic [XLEN-1:0] VEC_BRK    = 'h18,
    parameter logic [XLEN-1:0] VEC_EXC    = 'h20,
    parameter logic [XLEN-1:0] INSN_BYTES = 'h4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     exc_req,
    input  logic [EC_W-1:0]          exc_cause,
    input  logic [ESS_W-1:0]         exc_detail,
    input  logic [XLEN-1:0]          exc_addr,
    input  logic [FSR_W-1:0]         exc_fsr,
    input  logic                     brk_hw,
    input  logic                     brk_sw,
    input  logic                     trap_req,
    input  logic [REG_AW-1:0]        trap_link,
    input  logic [XLEN-1:0]          pc_cur,
    input  logic                     in_delay_slot,
    input  logic [XLEN-1:0]          branch_target,
    input  logic [XLEN-1:0]          msr_cur,
    output logic                     redirect_valid,
    output logic [XLEN-1:0]          redirect_pc,
    output logic                     gpr_we,
    output logic [REG_AW-1:0]        gpr_addr,
    output logic [XLEN-1:0]          gpr_data,
    output logic                     msr_we,
    output logic [XLEN-1:0]          msr_data,
    output logic                     esr_we,
    output logic [EC_W+ESS_W:0]      esr_data,
    output logic                     ear_we,
    output logic [XLEN-1:0]          ear_data,
    output logic                     btr_we,
    output logic [XLEN-1:0]          btr_data,
    output logic                     fsr_we,
    output logic [FSR_W-1:0]         fsr_data
);

    localparam int BRK_SRCS = 2;

    trapv_state_e      state;
    trapv_evt_e        evt;
    logic              in_run;

    logic [XLEN-1:0]   pc_q;
    logic              ds_q;
    logic [XLEN-1:0]   btgt_q;
    logic [EC_W-1:0]   ec_q;
    logic [ESS_W-1:0]  ess_q;
    logic [XLEN-1:0]   ear_q;
    logic [FSR_W-1:0]  fsr_q;
    logic [REG_AW-1:0] link_q;
    logic [XLEN-1:0]   msr_q;

    assign in_run = (state == ST_RUN);

    trapv_arbiter #(
        .BRK_SRCS (BRK_SRCS)
    ) u_arb (
        .exc_req  (exc_req),
        .msr_ee   (msr_cur[EE_BIT]),
        .brk_srcs ({brk_sw, brk_hw}),
        .msr_bip  (msr_cur[BIP_BIT]),
        .trap_req (trap_req),
        .evt      (evt)
    );

    trapv_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .state (state)
    );

    trapv_capture #(
        .XLEN   (XLEN),
        .REG_AW (REG_AW),
        .EC_W   (EC_W),
        .ESS_W  (ESS_W),
        .FSR_W  (FSR_W)
    ) u_cap (
        .clk     (clk),
        .load    (in_run),
        .pc_in   (pc_cur),
        .ds_in   (in_delay_slot),
        .btgt_in (branch_target),
        .ec_in   (exc_cause),
        .ess_in  (exc_detail),
        .ear_in  (exc_addr),
        .fsr_in  (exc_fsr),
        .link_in (trap_link),
        .msr_in  (msr_cur),
        .pc_q    (pc_q),
        .ds_q    (ds_q),
        .btgt_q  (btgt_q),
        .ec_q    (ec_q),
        .ess_q   (ess_q),
        .ear_q   (ear_q),
        .fsr_q   (fsr_q),
        .link_q  (link_q),
        .msr_q   (msr_q)
    );

    trapv_writer #(
        .XLEN       (XLEN),
        .REG_AW     (REG_AW),
        .EC_W       (EC_W),
        .ESS_W      (ESS_W),
        .FSR_W      (FSR_W),
        .EE_BIT     (EE_BIT),
        .EIP_BIT    (EIP_BIT),
        .BIP_BIT    (BIP_BIT),
        .EXC_LINK   (EXC_LINK),
        .BRK_LINK   (BRK_LINK),
        .RESET_MSR  (RESET_MSR),
        .VEC_RESET  (VEC_RESET),
        .VEC_TRAP   (VEC_TRAP),
        .VEC_BRK    (VEC_BRK),
        .VEC_EXC    (VEC_EXC),
        .INSN_BYTES (INSN_BYTES)
    ) u_wr (
        .state          (state),
        .pc_q           (pc_q),
        .ds_q           (ds_q),
        .btgt_q         (btgt_q),
        .ec_q           (ec_q),
        .ess_q          (ess_q),
        .ear_q          (ear_q),
        .fsr_q          (fsr_q),
        .link_q         (link_q),
        .msr_q          (msr_q),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .gpr_we         (gpr_we),
        .gpr_addr       (gpr_addr),
        .gpr_data       (gpr_data),
        .msr_we         (msr_we),
        .msr_data       (msr_data),
        .esr_we         (esr_we),
        .esr_data       (esr_data),
        .ear_we         (ear_we),
        .ear_data       (ear_data),
        .btr_we         (btr_we),
        .btr_data       (btr_data),
        .fsr_we         (fsr_we),
        .fsr_data       (fsr_data)
    );

endmodule

// File: rtl/trapv_checker.sv
module trapv_checker #(
    parameter int              XLEN       = 32,
    parameter int              REG_AW     = 5,
    parameter int              ESR_W      = 13,
    parameter int              EE_BIT     = 8,
    parameter int              EIP_BIT    = 9,
    parameter int              BIP_BIT    = 3,
    parameter int              EXC_LINK   = 17,
    parameter int              BRK_LINK   = 16,
    parameter logic [XLEN-1:0] VEC_RESET  = 'h00,
    parameter logic [XLEN-1:0] VEC_TRAP   = 'h08,
    parameter logic [XLEN-1:0] VEC_BRK    = 'h18,
    parameter logic [XLEN-1:0] VEC_EXC    = 'h20,
    parameter logic [XLEN-1:0] INSN_BYTES = 'h4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_run,
    input logic              exc_req,
    input logic [XLEN-1:0]   msr_cur,
    input logic              brk_hw,
    input logic              brk_sw,
    input logic              trap_req,
    input logic [REG_AW-1:0] trap_link,
    input logic              in_delay_slot,
    input logic [XLEN-1:0]   pc_cur,
    input logic [XLEN-1:0]   branch_target,
    input logic              redirect_valid,
    input logic [XLEN-1:0]   redirect_pc,
    input logic              gpr_we,
    input logic [REG_AW-1:0] gpr_addr,
    input logic [XLEN-1:0]   gpr_data,
    input logic              msr_we,
    input logic [XLEN-1:0]   msr_data,
    input logic              esr_we,
    input logic [ESR_W-1:0]  esr_data,
    input logic              btr_we,
    input logic [XLEN-1:0]   btr_data
);

    logic exc_ok;
    logic brk_req;
    logic brk_ok;

    assign exc_ok  = exc_req && msr_cur[EE_BIT];
    assign brk_req = brk_hw || brk_sw;
    assign brk_ok  = brk_req && !msr_cur[BIP_BIT];

    p_reset_vec_r1: assert property (@(posedge clk)
        rst |=> (redirect_valid && redirect_pc == VEC_RESET && esr_we
                 && esr_data == '0 && !gpr_we && !btr_we));

    p_exc_msr_r2: assert property (@(posedge clk) disable iff (rst)
        (in_run && exc_ok) |=> (redirect_valid && redirect_pc == VEC_EXC && msr_we
                                && !msr_data[EE_BIT] && msr_data[EIP_BIT]));

    p_ds_btr_r4: assert property (@(posedge clk) disable iff (rst)
        (in_run && exc_ok && in_delay_slot) |=> (btr_we && btr_data == $past(branch_target)
                                                 && !gpr_we && esr_data[ESR_W-1]));

    p_ret_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (in_run && exc_ok && !in_delay_slot) |=> (!btr_we && gpr_we
            && gpr_addr == REG_AW'(EXC_LINK) && gpr_data == $past(pc_cur) + INSN_BYTES
            && !esr_data[ESR_W-1]));

    p_brk_link_r6: assert property (@(posedge clk) disable iff (rst)
        (in_run && !exc_ok && brk_ok) |=> (redirect_pc == VEC_BRK && gpr_we
            && gpr_addr == REG_AW'(BRK_LINK) && gpr_data == $past(pc_cur)
            && msr_data[BIP_BIT] && !esr_we));

    p_brk_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (in_run && !exc_ok && brk_req && !brk_ok && !trap_req) |=> !redirect_valid);

    p_trap_link_r8: assert property (@(posedge clk) disable iff (rst)
        (in_run && !exc_ok && !brk_ok && trap_req) |=> (redirect_pc == VEC_TRAP && gpr_we
            && gpr_addr == $past(trap_link) && !msr_we));

    p_single_event_r10: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid);

endmodule

bind trap_vector_ctl trapv_checker #(
    .XLEN       (XLEN),
    .REG_AW     (REG_AW),
    .ESR_W      (EC_W + ESS_W + 1),
    .EE_BIT     (EE_BIT),
    .EIP_BIT    (EIP_BIT),
    .BIP_BIT    (BIP_BIT),
    .EXC_LINK   (EXC_LINK),
    .BRK_LINK   (BRK_LINK),
    .VEC_RESET  (VEC_RESET),
    .VEC_TRAP   (VEC_TRAP),
    .VEC_BRK    (VEC_BRK),
    .VEC_EXC    (VEC_EXC),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_run         (in_run),
    .exc_req        (exc_req),
    .msr_cur        (msr_cur),
    .brk_hw         (brk_hw),
    .brk_sw         (brk_sw),
    .trap_req       (trap_req),
    .trap_link      (trap_link),
    .in_delay_slot  (in_delay_slot),
    .pc_cur         (pc_cur),
    .branch_target  (branch_target),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .gpr_we         (gpr_we),
    .gpr_addr       (gpr_addr),
    .gpr_data       (gpr_data),
    .msr_we         (msr_we),
    .msr_data       (msr_data),
    .esr_we         (esr_we),
    .esr_data       (esr_data),
    .btr_we         (btr_we),
    .btr_data       (btr_data)
);

// File: tb/trap_vector_ctl_test.sv
module trap_vector_ctl_test;

    localparam logic [31:0] T_RESET_MSR = 32'h0000_0100;
    localparam logic [31:0] MSR_BASE    = 32'h8000_0021;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_cause = '0;
    logic [6:0]  exc_detail = '0;
    logic [31:0] exc_addr = '0;
    logic [4:0]  exc_fsr = '0;
    logic        brk_hw = 1'b0;
    logic        brk_sw = 1'b0;
    logic        trap_req = 1'b0;
    logic [4:0]  trap_link = '0;
    logic [31:0] pc_cur = '0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] branch_target = '0;
    logic [31:0] msr_cur = MSR_BASE;

    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        gpr_we;
    logic [4:0]  gpr_addr;
    logic [31:0] gpr_data;
    logic        msr_we;
    logic [31:0] msr_data;
    logic        esr_we;
    logic [12:0] esr_data;
    logic        ear_we;
    logic [31:0] ear_data;
    logic        btr_we;
    logic [31:0] btr_data;
    logic        fsr_we;
    logic [4:0]  fsr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trap_vector_ctl #(.RESET_MSR(T_RESET_MSR)) uut (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_detail(exc_detail), .exc_addr(exc_addr), .exc_fsr(exc_fsr),
        .brk_hw(brk_hw), .brk_sw(brk_sw), .trap_req(trap_req), .trap_link(trap_link),
        .pc_cur(pc_cur), .in_delay_slot(in_delay_slot), .branch_target(branch_target),
        .msr_cur(msr_cur), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .gpr_we(gpr_we), .gpr_addr(gpr_addr), .gpr_data(gpr_data),
        .msr_we(msr_we), .msr_data(msr_data), .esr_we(esr_we), .esr_data(esr_data),
        .ear_we(ear_we), .ear_data(ear_data), .btr_we(btr_we), .btr_data(btr_data),
        .fsr_we(fsr_we), .fsr_data(fsr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, what, act, exp);
    endtask

    // Idle outputs: nothing written, nothing redirected.
    task automatic check_idle(input string req);
        check_eq(req, "redirect_valid idle", 32'(redirect_valid), 0);
        check_eq(req, "write enables idle",
                 {26'd0, gpr_we, msr_we, esr_we, ear_we, btr_we, fsr_we}, 0);
    endtask

    task automatic check_reset_outputs(input string tag);
        check_eq(tag, "reset redirect_valid", 32'(redirect_valid), 1);
        check_eq(tag, "reset vector", redirect_pc, 32'h0);
        check_eq(tag, "reset msr write", {31'd0, msr_we}, 1);
        check_eq(tag, "reset msr value", msr_data, T_RESET_MSR);
        check_eq(tag, "reset esr/ear/fsr enables", {29'd0, esr_we, ear_we, fsr_we}, 32'h7);
        check_eq(tag, "reset esr/ear/fsr zero", 32'(esr_data) | ear_data | 32'(fsr_data), 0);
        check_eq(tag, "reset no gpr/btr write", {30'd0, gpr_we, btr_we}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outputs("R1");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R10");

        for (int c = 0; c < 128; c++) begin
            logic e_req, e_en, b_hw, b_sw, b_ip, t_req, ds;
            logic [31:0] exp_msr;
            e_req = c[0]; e_en = c[1]; b_hw = c[2]; b_sw = c[3];
            b_ip  = c[4]; t_req = c[5]; ds = c[6];

            exc_req       = e_req;
            brk_hw        = b_hw;
            brk_sw        = b_sw;
            trap_req      = t_req;
            in_delay_slot = ds;
            exc_cause     = 5'(c) ^ 5'h15;
            exc_detail    = 7'(c * 3);
            exc_addr      = 32'hE000_0000 | 32'(c);
            exc_fsr       = 5'(c + 1);
            trap_link     = 5'((c % 31) + 1);
            branch_target = 32'h0080_0000 + 32'(c * 8);
            pc_cur        = (c == 3) ? 32'hFFFF_FFFC : 32'h0040_0000 + 32'(c * 12);
            msr_cur       = MSR_BASE;
            msr_cur[8]    = e_en;
            msr_cur[3]    = b_ip;

            @(negedge clk);
            if (e_req && e_en) begin
                exp_msr = msr_cur; exp_msr[8] = 1'b0; exp_msr[9] = 1'b1;
                check_eq("R2", "exception vector", redirect_pc, 32'h20);
                check_eq("R2", "exception msr", msr_data, exp_msr);
                check_eq("R3", "esr fields", 32'(esr_data), 32'({ds, exc_detail, exc_cause}));
                check_eq("R3", "ear value", ear_data, exc_addr);
                check_eq("R3", "fsr value", 32'(fsr_data), 32'(exc_fsr));
                if (ds) begin
                    check_eq("R4", "btr write", {31'd0, btr_we}, 1);
                    check_eq("R4", "btr value", btr_data, branch_target);
                    check_eq("R4", "no return write", {31'd0, gpr_we}, 0);
                end else begin
                    check_eq("R5", "return write", {26'd0, gpr_we, gpr_addr}, {26'd0, 1'b1, 5'd17});
                    check_eq("R5", "return value", gpr_data, pc_cur + 32'd4);
                    check_eq("R5", "no btr write", {31'd0, btr_we}, 0);
                end
                if (b_hw || b_sw || t_req)
                    check_eq("R9", "exception wins", redirect_pc, 32'h20);
            end else if ((b_hw || b_sw) && !b_ip) begin
                exp_msr = msr_cur; exp_msr[3] = 1'b1;
                check_eq("R6", "break vector", redirect_pc, 32'h18);
                check_eq("R6", "break link", {26'd0, gpr_we, gpr_addr}, {26'd0, 1'b1, 5'd16});
                check_eq("R6", "break pc saved", gpr_data, pc_cur);
                check_eq("R6", "break msr", msr_data, exp_msr);
                check_eq("R6", "break no esr", {31'd0, esr_we}, 0);
                if (e_req || t_req)
                    check_eq("R9", "break priority", redirect_pc, 32'h18);
            end else if (t_req) begin
                check_eq("R8", "trap vector", redirect_pc, 32'h08);
                check_eq("R8", "trap link", {26'd0, gpr_we, gpr_addr}, {26'd0, 1'b1, trap_link});
                check_eq("R8", "trap pc saved", gpr_data, pc_cur);
                check_eq("R8", "trap no msr", {31'd0, msr_we}, 0);
                if (e_req || b_hw || b_sw)
                    check_eq("R9", "masked requests do not block", redirect_pc, 32'h08);
            end else begin
                if (b_hw || b_sw)      check_idle("R7");
                else if (e_req)        check_idle("R7");
                else                   check_idle("R10");
            end
            // Requests held through the vectoring cycle must be dropped.
            @(negedge clk);
            check_idle("R10");
        end

        // Reset arriving together with an allowed exception.
        exc_req = 1'b1; msr_cur = MSR_BASE | 32'h100; in_delay_slot = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check_reset_outputs("R1");
        check_eq("R9", "reset beats exception", redirect_pc, 32'h0);
        exc_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_idle("R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule